// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block carries out a single step of the bus search that discovers device identifiers on an open-drain 1-Wire line. A start strobe launches three slots back to back: two read slots, then one write slot. The two read slots return a bit and its complement from all devices still taking part. The write slot then picks the branch to follow. If the two reads disagree, the first read bit decides. If both read 0, a direction input supplied by the search controller decides. If both read 1, no device answered and a one is written.

The engine drives a single pull-down enable for the line and samples the line level it receives. It reports the first read bit, the second read bit and the direction actually written. Each status bit updates at the sample point of its own slot, so a controller polling the outputs sees them fill in as the step proceeds. While the step runs a busy flag stays high. A start that arrives during that time has no effect and is flagged on a one-cycle rejection pulse. Every slot timing is a parameter given in clock cycles.

Top module: `owt_triplet`

## Requirements
- R1: While reset is applied, and right after it, `busy_o`, `done_o`, `rejected_o`, `pull_low_o`, `bit1_o`, `bit2_o` and `dir_taken_o` are all 0.
- R2: A start accepted at a clock edge (`start_i` high while `busy_o` is low) produces exactly three low pulses on `pull_low_o`, one at the first cycle of each of three consecutive slots of `SLOT_CYC` cycles. The first slot begins in the cycle after the accepting edge.
- R3: In each of the two read slots, `pull_low_o` is high for the first `LOW_CYC` cycles and low for the rest of the slot. The line is sampled in the slot cycle whose index is `SAMPLE_CYC` (the first cycle of a slot has index 0).
- R4: In the write slot, a write-one holds `pull_low_o` high for `LOW_CYC` cycles and a write-zero holds it high for `W0_CYC` cycles. The line is released for the rest of the slot, which leaves a recovery gap.
- R5: The written bit depends on the first read bit (b1) and the second (b2). When b1=0 and b2=0 it equals bit 7 of `dir_byte_i` as captured at the accepting edge, and bits 6..0 are ignored. When b1=0 and b2=1 it is 0. When b1=1 it is 1, whatever the value of b2.
- R6: `bit1_o` takes the first slot's sampled line value in the cycle after that slot's sample cycle, that is, `SAMPLE_CYC+2` cycles after the accepting edge. `bit2_o` and `dir_taken_o` keep their earlier values at that point.
- R7: `bit2_o` takes the second slot's sampled line value `SLOT_CYC+SAMPLE_CYC+2` cycles after the accepting edge. `dir_taken_o` takes the bit to be written, as given in R5, in that same cycle. All three status bits then hold until the next step.
- R8: `busy_o` is high for exactly `3*SLOT_CYC` cycles, starting in the cycle after the accepting edge. A start given in the cycle `busy_o` falls is accepted.
- R9: `done_o` is high for one cycle, the first cycle in which `busy_o` is low again.
- R10: A start while `busy_o` is high does not change the running step, its timing or its result. `rejected_o` is high for one cycle, the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe for one search step |
| dir_byte_i | input | 8 | Command byte; bit 7 is the direction to take when both reads are 0 |
| line_i | input | 1 | Sampled level of the 1-Wire line (1 = released high) |
| pull_low_o | output | 1 | Enable for the open-drain pull-down of the line |
| busy_o | output | 1 | High while the three slots run |
| done_o | output | 1 | One-cycle pulse at the end of the step |
| rejected_o | output | 1 | One-cycle pulse when a start arrives while busy |
| bit1_o | output | 1 | Line value sampled in the first read slot |
| bit2_o | output | 1 | Line value sampled in the second read slot |
| dir_taken_o | output | 1 | Bit written in the write slot |

## Verification
The bench builds the engine with `SLOT_CYC=20`, `LOW_CYC=2`, `SAMPLE_CYC=6` and `W0_CYC=14`. At these values one step takes 60 cycles, so every slot boundary, each staged status update and the exact write-zero and write-one pulse lengths can be counted cycle by cycle. A device model in the bench answers each read slot by pulling the line. This covers all four read-bit combinations with different direction bytes, a start rejected in the middle of a step, a start accepted in the done cycle, and a reset applied mid-step.

// File: rtl/owt_pkg.sv
package owt_pkg;
  typedef enum logic [1:0] {
    SLOT_RD1  = 2'd0,
    SLOT_RD2  = 2'd1,
    SLOT_WR   = 2'd2,
    SLOT_IDLE = 2'd3
  } slot_e;
endpackage

// File: rtl/owt_slot_timer.sv
module owt_slot_timer
  import owt_pkg::*;
#(
  parameter int SLOT_CYC = 3500,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  output slot_e         slot_o,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o
);
  slot_e         slot_q, slot_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic          slot_end;

  assign slot_end = busy_q && (cnt_q == CW'(SLOT_CYC - 1));

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_ok) begin
      slot_d = SLOT_RD1;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (slot_end) begin
      cnt_d = '0;
      unique case (slot_q)
        SLOT_RD1: slot_d = SLOT_RD2;
        SLOT_RD2: slot_d = SLOT_WR;
        default: begin
          slot_d = SLOT_IDLE;
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      endcase
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign slot_o = slot_q;
  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/owt_wire_drive.sv
module owt_wire_drive
  import owt_pkg::*;
#(
  parameter int SLOT_CYC = 3500,
  parameter int LOW_CYC  = 300,
  parameter int W0_CYC   = 3000,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic          busy,
  input  slot_e         slot,
  input  logic [CW-1:0] cnt,
  input  logic          wbit,
  output logic          pull_low_o
);
  logic [CW-1:0] low_len;

  always_comb begin
    if (slot == SLOT_WR && !wbit) low_len = CW'(W0_CYC);
    else                          low_len = CW'(LOW_CYC);
    pull_low_o = busy && (cnt < low_len);
  end
endmodule

// File: rtl/owt_result.sv
module owt_result
  import owt_pkg::*;
#(
  parameter int SLOT_CYC   = 3500,
  parameter int SAMPLE_CYC = 650,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          dir_in,
  input  logic          busy,
  input  slot_e         slot,
  input  logic [CW-1:0] cnt,
  input  logic          line_i,
  output logic          bit1_o,
  output logic          bit2_o,
  output logic          dir_o
);
  logic dir_req_q, bit1_q, bit2_q, dir_q;
  logic hit, en_b1, en_b2;
  logic bit2_d, dir_d;

  always_comb begin
    hit    = busy && (cnt == CW'(SAMPLE_CYC));
    en_b1  = hit && (slot == SLOT_RD1);
    en_b2  = hit && (slot == SLOT_RD2);
    bit2_d = line_i;
    // disagreeing reads follow the first bit; 0/0 follows the request
    dir_d  = bit1_q | (~line_i & dir_req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_req_q <= 1'b0;
      bit1_q    <= 1'b0;
      bit2_q    <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      if (start_ok) dir_req_q <= dir_in;
      if (en_b1)    bit1_q    <= line_i;
      if (en_b2) begin
        bit2_q <= bit2_d;
        dir_q  <= dir_d;
      end
    end
  end

  assign bit1_o = bit1_q;
  assign bit2_o = bit2_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/owt_triplet.sv
module owt_triplet
  import owt_pkg::*;
#(
  parameter int SLOT_CYC   = 3500,
  parameter int LOW_CYC    = 300,
  parameter int SAMPLE_CYC = 650,
  parameter int W0_CYC     = 3000,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] dir_byte_i,
  input  logic       line_i,
  output logic       pull_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rejected_o,
  output logic       bit1_o,
  output logic       bit2_o,
  output logic       dir_taken_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          start_ok, rej_d, rej_q;
  slot_e         slot;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    start_ok = start_i && !busy_o;
    rej_d    = start_i && busy_o;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rej_q <= 1'b0;
    else            rej_q <= rej_d;
  end
  assign rejected_o = rej_q;

  owt_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start_ok(start_ok),
    .slot_o(slot), .cnt_o(cnt), .busy_o(busy_o), .done_o(done_o)
  );

  owt_wire_drive #(.SLOT_CYC(SLOT_CYC), .LOW_CYC(LOW_CYC), .W0_CYC(W0_CYC)) u_drive (
    .busy(busy_o), .slot(slot), .cnt(cnt), .wbit(dir_taken_o),
    .pull_low_o(pull_low_o)
  );

  owt_result #(.SLOT_CYC(SLOT_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_result (
    .clk(clk), .rst_n(rst_int_n), .start_ok(start_ok), .dir_in(dir_byte_i[7]),
    .busy(busy_o), .slot(slot), .cnt(cnt), .line_i(line_i),
    .bit1_o(bit1_o), .bit2_o(bit2_o), .dir_o(dir_taken_o)
  );
endmodule

// File: rtl/owt_triplet_chk.sv
module owt_triplet_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic pull_low_o,
  input logic busy_o,
  input logic done_o,
  input logic rejected_o,
  input logic bit1_o,
  input logic bit2_o,
  input logic dir_taken_o
);
  assert_low_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> busy_o);

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable({bit1_o, bit2_o, dir_taken_o}));

  assert_first_bit_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && bit1_o) |-> dir_taken_o);

  assert_zero_one_writes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bit1_o && bit2_o) |-> !dir_taken_o);

  assert_done_at_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_busy_fall_gives_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_reject_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rejected_o |-> ($past(busy_o) && $past(start_i)));
endmodule

bind owt_triplet owt_triplet_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pull_low_o(pull_low_o),
  .busy_o(busy_o), .done_o(done_o), .rejected_o(rejected_o),
  .bit1_o(bit1_o), .bit2_o(bit2_o), .dir_taken_o(dir_taken_o)
);

// File: tb/owt_triplet_test.sv
module owt_triplet_test;
  localparam int SLOT = 20;
  localparam int LOW  = 2;
  localparam int SAMP = 6;
  localparam int W0   = 14;

  typedef struct packed {
    logic       b1;
    logic       b2;
    logic [7:0] dbyte;
    logic       w;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 8'h80, 1'b1},
    '{1'b0, 1'b0, 8'h7F, 1'b0},
    '{1'b0, 1'b0, 8'hFF, 1'b1},
    '{1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b0, 1'b1, 8'h80, 1'b0},
    '{1'b0, 1'b1, 8'hFF, 1'b0},
    '{1'b1, 1'b0, 8'h00, 1'b1},
    '{1'b1, 1'b1, 8'h00, 1'b1}
  };

  logic clk, rst_n, start_i, line_i, dev_low;
  logic [7:0] dir_byte_i;
  logic pull_low_o, busy_o, done_o, rejected_o, bit1_o, bit2_o, dir_taken_o;
  int total, fails, cyc;

  assign line_i = !(pull_low_o || dev_low);

  owt_triplet #(.SLOT_CYC(SLOT), .LOW_CYC(LOW), .SAMPLE_CYC(SAMP), .W0_CYC(W0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_byte_i(dir_byte_i),
    .line_i(line_i), .pull_low_o(pull_low_o), .busy_o(busy_o), .done_o(done_o),
    .rejected_o(rejected_o), .bit1_o(bit1_o), .bit2_o(bit2_o),
    .dir_taken_o(dir_taken_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // One full step. pre: start already accepted at the previous edge.
  // rej_at: cycle in which a rejected start is given (0 = none).
  // chain: give a new start in the done cycle.
  task automatic run_seq(input logic b1, input logic b2, input logic [7:0] dbyte,
                         input logic expw, input int rej_at, input bit pre,
                         input bit chain);
    int rd_err, wr_err, busy_err, pulses;
    logic prev_pull, old_b2, old_dir, exp_pull;
    rd_err = 0; wr_err = 0; busy_err = 0; pulses = 0; prev_pull = 1'b0;
    old_b2 = bit2_o; old_dir = dir_taken_o;
    if (!pre) begin
      @(negedge clk);
      start_i = 1'b1;
      dir_byte_i = dbyte;
    end
    for (int k = 1; k <= 3*SLOT + 1; k++) begin
      int g, s, c;
      @(negedge clk);
      g = k - 1; s = g / SLOT; c = g % SLOT;
      if (k == 1) begin start_i = 1'b0; dir_byte_i = ~dbyte; end
      if (rej_at != 0 && k == rej_at) begin start_i = 1'b1; dir_byte_i = ~dbyte; end
      if (rej_at != 0 && k == rej_at + 1) start_i = 1'b0;
      dev_low = (k <= 3*SLOT) && (((s == 0) && !b1) || ((s == 1) && !b2)) && (c <= SAMP + 1);
      if (k <= 3*SLOT) begin
        if (!busy_o || done_o) busy_err++;
        if (s < 2) begin
          exp_pull = (c < LOW);
          if (pull_low_o !== exp_pull) rd_err++;
        end else begin
          exp_pull = (c < (expw ? LOW : W0));
          if (pull_low_o !== exp_pull) wr_err++;
        end
        if (pull_low_o && !prev_pull) pulses++;
        prev_pull = pull_low_o;
      end
      if (rej_at != 0 && k == rej_at + 1)
        chk(rejected_o === 1'b1, "R10 reject pulse", rejected_o, 1);
      if (rej_at != 0 && k == rej_at + 2)
        chk(rejected_o === 1'b0, "R10 reject one cycle", rejected_o, 0);
      if (k == SAMP + 2) begin
        chk(bit1_o === b1, "R6 first bit", bit1_o, b1);
        chk({bit2_o, dir_taken_o} === {old_b2, old_dir}, "R6 later bits unchanged",
            {bit2_o, dir_taken_o}, {old_b2, old_dir});
      end
      if (k == SLOT + SAMP + 1)
        chk(bit2_o === old_b2, "R7 second bit not early", bit2_o, old_b2);
      if (k == SLOT + SAMP + 2) begin
        chk(bit2_o === b2, "R7 second bit", bit2_o, b2);
        chk(dir_taken_o === expw, "R5 direction taken", dir_taken_o, expw);
      end
      if (k == 3*SLOT + 1) begin
        chk(done_o === 1'b1 && busy_o === 1'b0, "R9 done with busy low",
            {done_o, busy_o}, 2'b10);
        chk({bit1_o, bit2_o, dir_taken_o} === {b1, b2, expw}, "R7 status held",
            {bit1_o, bit2_o, dir_taken_o}, {b1, b2, expw});
        if (chain) begin start_i = 1'b1; dir_byte_i = 8'h80; end
      end
    end
    chk(busy_err == 0, "R8 busy window", busy_err, 0);
    chk(pulses == 3, "R2 three slots", pulses, 3);
    chk(rd_err == 0, "R3 read slot drive", rd_err, 0);
    chk(wr_err == 0, "R4 write slot drive", wr_err, 0);
    if (!chain) begin
      @(negedge clk);
      chk(done_o === 1'b0, "R9 done one cycle", done_o, 0);
    end
  endtask

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; start_i = 1'b0; dir_byte_i = 8'h00; dev_low = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, rejected_o, pull_low_o, bit1_o, bit2_o, dir_taken_o} === 7'd0,
        "R1 reset state", {busy_o, done_o, rejected_o, pull_low_o, bit1_o, bit2_o, dir_taken_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, pull_low_o, bit1_o} === 4'd0, "R1 after release",
        {busy_o, done_o, pull_low_o, bit1_o}, 0);

    for (int i = 0; i < 8; i++)
      run_seq(VECS[i].b1, VECS[i].b2, VECS[i].dbyte, VECS[i].w, 0, 1'b0, 1'b0);

    // R10: start mid-step with opposite direction byte is ignored
    run_seq(1'b0, 1'b0, 8'h80, 1'b1, 10, 1'b0, 1'b0);
    run_seq(1'b0, 1'b0, 8'h00, 1'b0, 30, 1'b0, 1'b0);

    // R8: start in the done cycle is accepted
    run_seq(1'b1, 1'b0, 8'h00, 1'b1, 0, 1'b0, 1'b1);
    run_seq(1'b0, 1'b0, 8'h80, 1'b1, 0, 1'b1, 1'b0);

    // R1: reset in the middle of a step
    @(negedge clk); start_i = 1'b1; dir_byte_i = 8'h80;
    @(negedge clk); start_i = 1'b0;
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy_o, pull_low_o, bit1_o, bit2_o, dir_taken_o} === 5'd0, "R1 mid-step reset",
        {busy_o, pull_low_o, bit1_o, bit2_o, dir_taken_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0, "R1 idle after reset", busy_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule